// File: doc/BRIEF.md
# UART Interrupt and Status Controller

This block gathers every interrupt-worthy condition of a serial port into one place. It watches the fill levels of the transmit and receive FIFOs, and raises a source bit when a level moves across a trigger point. Each trigger point is a selectable fraction of the FIFO depth. It also records receiver error pulses, a receive-timeout event, a change on the clear-to-send line and the end of transmission. Pending sources collect in a sticky raw status register. An enable mask gates them into a masked view, and the OR of that view, registered, is the single interrupt line.

Software-facing writes reach the block as plain write strobes with a data word, already decoded by the bus logic. There are separate strobes for mask set, mask clear, write-one-to-clear of pending sources, and clearing the receiver error register. The block also produces the request-to-send output. Under receive flow control it follows free space in the receive FIFO; otherwise it follows a software-driven level. No data stream passes through the block, so it has no valid/ready handshake. Every pin is a level or a single-cycle strobe, and nothing applies back-pressure.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Trigger select codes map to fractions of DEPTH as follows: 0 = 1/8, 1 = 2/8, 2 = 4/8, 3 = 6/8, 4 = 7/8, and any other code = 4/8. The threshold is floor(DEPTH*eighths/8).
- R2: The receive source (raw bit 0) sets when the receive level goes from below the threshold to at or above it. It does not set again while the level stays at or above the threshold.
- R3: In FIFO mode (tx_eot_mode=0), the transmit source (raw bit 1) sets when the transmit level goes from above the threshold to at or below it. Rising levels never set it.
- R4: In end-of-transmission mode (tx_eot_mode=1), the transmit source sets only when the condition "transmit level is zero and tx_shift_idle is high" becomes true. Threshold crossings are ignored in this mode.
- R5: Raw status bit positions are: 2 = receive timeout, 3 = framing, 4 = parity, 5 = break, 6 = overrun, 7 = CTS change. Each event sets its bit one clock after the event. Raw bits stay set until they are cleared.
- R6: masked_status equals raw_status AND mask. A mask-set write ORs its data into the mask, and a mask-clear write removes its bits. When both hit the same bit in the same cycle, the bit ends up set.
- R7: irq is high one clock after masked_status is non-zero, and low one clock after masked_status is zero.
- R8: An int_clr_we write clears every raw bit where int_clr_bits is 1. A source event in the same cycle keeps its bit set.
- R9: err_status holds framing (bit 0), parity (bit 1), break (bit 2) and overrun (bit 3). Each bit is set one clock after its pulse. Any err_clr_we clears all four, except a pulse in that same cycle. Clearing err_status leaves raw_status unchanged.
- R10: rts_out is registered. With rx_flow_en=1 it is high exactly while rx_level < DEPTH. With rx_flow_en=0 it follows sw_rts.
- R11: After reset, raw_status, the mask, masked_status, irq, err_status and rts_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_trig_sel | input | 3 | Transmit trigger fraction code |
| rx_trig_sel | input | 3 | Receive trigger fraction code |
| tx_eot_mode | input | 1 | 1 selects end-of-transmission transmit interrupt |
| tx_shift_idle | input | 1 | Transmit shifter has sent all stop bits |
| rx_overrun_pulse | input | 1 | Receiver overrun event |
| rx_break_pulse | input | 1 | Receiver break event |
| rx_parity_pulse | input | 1 | Receiver parity error event |
| rx_frame_pulse | input | 1 | Receiver framing error event |
| rx_timeout_evt | input | 1 | Receive timeout event |
| cts_change | input | 1 | Clear-to-send line changed |
| mask_set_we | input | 1 | Mask set strobe |
| mask_set_bits | input | 8 | Bits to enable |
| mask_clr_we | input | 1 | Mask clear strobe |
| mask_clr_bits | input | 8 | Bits to disable |
| int_clr_we | input | 1 | Pending-source clear strobe |
| int_clr_bits | input | 8 | Write-one-to-clear data |
| err_clr_we | input | 1 | Error register clear strobe (data ignored) |
| rx_flow_en | input | 1 | Receive hardware flow control enable |
| sw_rts | input | 1 | Software RTS level when flow control is off |
| raw_status | output | 8 | Pending sources before masking |
| masked_status | output | 8 | Pending sources after masking |
| irq | output | 1 | Combined interrupt |
| err_status | output | 4 | Receiver error register |
| rts_out | output | 1 | Request-to-send, active high |

## Verification
The assertions take the following for granted:
- Each error pulse, timeout event, CTS change and write strobe lasts one cycle and is driven synchronously.
- Fill levels never exceed DEPTH.
- The trigger codes change only while the level is steady, so a code change alone is not counted as a crossing.

The stimulus follows these rules. It drives every input at the falling clock edge and raises each strobe for exactly one cycle. It moves the levels in steps that stay inside 0..DEPTH. It sets trigger codes before the level moves, which keeps every expected crossing unambiguous.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 8;
  localparam int NERR = 4;

  localparam int SRC_RX  = 0;
  localparam int SRC_TX  = 1;
  localparam int SRC_RTO = 2;
  localparam int SRC_FRM = 3;
  localparam int SRC_PAR = 4;
  localparam int SRC_BRK = 5;
  localparam int SRC_OVR = 6;
  localparam int SRC_CTS = 7;

  localparam int ERR_FRM = 0;
  localparam int ERR_PAR = 1;
  localparam int ERR_BRK = 2;
  localparam int ERR_OVR = 3;

  typedef enum logic [2:0] {
    TRIG_1_8 = 3'd0,
    TRIG_2_8 = 3'd1,
    TRIG_4_8 = 3'd2,
    TRIG_6_8 = 3'd3,
    TRIG_7_8 = 3'd4
  } trig_sel_e;

  // number of eighths of the FIFO depth selected by a trigger code
  function automatic int trig_eighths(logic [2:0] sel);
    case (sel)
      TRIG_1_8: return 1;
      TRIG_2_8: return 2;
      TRIG_4_8: return 4;
      TRIG_6_8: return 6;
      TRIG_7_8: return 7;
      default:  return 4;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_level_trig.sv
module uart_irq_level_trig
  import uart_irq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int LVL_W   = 5,
  parameter bit FALLING = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [2:0]       sel,
  output logic             hit
);
  logic [LVL_W-1:0] prev_q;
  logic [LVL_W-1:0] thr;

  always_comb thr = LVL_W'((DEPTH * trig_eighths(sel)) / 8);

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  generate
    if (FALLING) begin : g_fall
      // draining FIFO: fire once when the level drops to or below threshold
      assign hit = (prev_q > thr) && (level <= thr);
    end else begin : g_rise
      // filling FIFO: fire once when the level reaches threshold
      assign hit = (prev_q < thr) && (level >= thr);
    end
  endgenerate
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic            mask_set_we,
  input  logic [NSRC-1:0] mask_set_bits,
  input  logic            mask_clr_we,
  input  logic [NSRC-1:0] mask_clr_bits,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_bits,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] masked,
  output logic            irq
);
  logic [NSRC-1:0] raw_q, mask_q;
  logic [NSRC-1:0] clr_eff, mset_eff, mclr_eff;
  logic            irq_q;

  always_comb begin
    clr_eff  = clr_we      ? clr_bits      : '0;
    mset_eff = mask_set_we ? mask_set_bits : '0;
    mclr_eff = mask_clr_we ? mask_clr_bits : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= (raw_q & ~clr_eff) | set_vec;   // a new event beats a clear
      mask_q <= (mask_q & ~mclr_eff) | mset_eff; // a set beats a clear
      irq_q  <= |(raw_q & mask_q);
    end
  end

  assign raw    = raw_q;
  assign masked = raw_q & mask_q;
  assign irq    = irq_q;
endmodule

// File: rtl/uart_irq_errreg.sv
module uart_irq_errreg
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NERR-1:0] pulses,
  input  logic            clr_we,
  output logic [NERR-1:0] err
);
  logic [NERR-1:0] err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (clr_we ? '0 : err_q) | pulses;
  end

  assign err = err_q;
endmodule

// File: rtl/uart_irq_rts.sv
module uart_irq_rts #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             flow_en,
  input  logic             sw_level,
  output logic             rts
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);
  logic rts_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       rts_q <= 1'b0;
    else if (flow_en) rts_q <= (rx_level < FULL);
    else              rts_q <= sw_level;
  end

  assign rts = rts_q;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [2:0]       tx_trig_sel,
  input  logic [2:0]       rx_trig_sel,
  input  logic             tx_eot_mode,
  input  logic             tx_shift_idle,
  input  logic             rx_overrun_pulse,
  input  logic             rx_break_pulse,
  input  logic             rx_parity_pulse,
  input  logic             rx_frame_pulse,
  input  logic             rx_timeout_evt,
  input  logic             cts_change,
  input  logic             mask_set_we,
  input  logic [7:0]       mask_set_bits,
  input  logic             mask_clr_we,
  input  logic [7:0]       mask_clr_bits,
  input  logic             int_clr_we,
  input  logic [7:0]       int_clr_bits,
  input  logic             err_clr_we,
  input  logic             rx_flow_en,
  input  logic             sw_rts,
  output logic [7:0]       raw_status,
  output logic [7:0]       masked_status,
  output logic             irq,
  output logic [3:0]       err_status,
  output logic             rts_out
);
  logic rx_hit, tx_fifo_hit, tx_hit;
  logic eot_cond, eot_prev_q, eot_hit;
  logic [NSRC-1:0] set_vec;
  logic [NERR-1:0] err_pulses;

  uart_irq_level_trig #(.DEPTH(DEPTH), .LVL_W(LVL_W), .FALLING(1'b0)) u_rx_trig (
    .clk(clk), .rst_n(rst_n), .level(rx_level), .sel(rx_trig_sel), .hit(rx_hit)
  );

  uart_irq_level_trig #(.DEPTH(DEPTH), .LVL_W(LVL_W), .FALLING(1'b1)) u_tx_trig (
    .clk(clk), .rst_n(rst_n), .level(tx_level), .sel(tx_trig_sel), .hit(tx_fifo_hit)
  );

  // end of transmission: FIFO empty and last stop bit gone
  assign eot_cond = (tx_level == '0) && tx_shift_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) eot_prev_q <= 1'b1;
    else        eot_prev_q <= eot_cond;
  end

  assign eot_hit = eot_cond && !eot_prev_q;
  assign tx_hit  = tx_eot_mode ? eot_hit : tx_fifo_hit;

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_RX]  = rx_hit;
    set_vec[SRC_TX]  = tx_hit;
    set_vec[SRC_RTO] = rx_timeout_evt;
    set_vec[SRC_FRM] = rx_frame_pulse;
    set_vec[SRC_PAR] = rx_parity_pulse;
    set_vec[SRC_BRK] = rx_break_pulse;
    set_vec[SRC_OVR] = rx_overrun_pulse;
    set_vec[SRC_CTS] = cts_change;

    err_pulses          = '0;
    err_pulses[ERR_FRM] = rx_frame_pulse;
    err_pulses[ERR_PAR] = rx_parity_pulse;
    err_pulses[ERR_BRK] = rx_break_pulse;
    err_pulses[ERR_OVR] = rx_overrun_pulse;
  end

  uart_irq_status u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .mask_set_we(mask_set_we), .mask_set_bits(mask_set_bits),
    .mask_clr_we(mask_clr_we), .mask_clr_bits(mask_clr_bits),
    .clr_we(int_clr_we), .clr_bits(int_clr_bits),
    .raw(raw_status), .masked(masked_status), .irq(irq)
  );

  uart_irq_errreg u_err (
    .clk(clk), .rst_n(rst_n), .pulses(err_pulses), .clr_we(err_clr_we), .err(err_status)
  );

  uart_irq_rts #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .flow_en(rx_flow_en),
    .sw_level(sw_rts), .rts(rts_out)
  );
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_overrun_pulse,
  input logic             rx_break_pulse,
  input logic             rx_parity_pulse,
  input logic             rx_frame_pulse,
  input logic             rx_timeout_evt,
  input logic             int_clr_we,
  input logic             err_clr_we,
  input logic             rx_flow_en,
  input logic             sw_rts,
  input logic [7:0]       raw_status,
  input logic [7:0]       masked_status,
  input logic             irq,
  input logic [3:0]       err_status,
  input logic             rts_out
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  p_masked_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_status & ~raw_status) == 8'h00);

  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(masked_status != 8'h00)));

  p_raw_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !int_clr_we |=> (($past(raw_status) & ~raw_status) == 8'h00));

  p_timeout_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout_evt |=> raw_status[2]);

  p_overrun_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun_pulse |=> (err_status[3] && raw_status[6]));

  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_we && !rx_overrun_pulse && !rx_break_pulse && !rx_parity_pulse && !rx_frame_pulse)
    |=> (err_status == 4'h0));

  p_rts_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flow_en && rx_level == FULL) |=> !rts_out);

  p_rts_sw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_flow_en |=> (rts_out == $past(sw_rts)));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_level(rx_level),
  .rx_overrun_pulse(rx_overrun_pulse), .rx_break_pulse(rx_break_pulse),
  .rx_parity_pulse(rx_parity_pulse), .rx_frame_pulse(rx_frame_pulse),
  .rx_timeout_evt(rx_timeout_evt), .int_clr_we(int_clr_we), .err_clr_we(err_clr_we),
  .rx_flow_en(rx_flow_en), .sw_rts(sw_rts), .raw_status(raw_status),
  .masked_status(masked_status), .irq(irq), .err_status(err_status), .rts_out(rts_out)
);

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  localparam int K_RAW = 0, K_MSK = 1, K_IRQ = 2, K_ERR = 3, K_RTS = 4;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
  logic [2:0] tx_trig_sel = 3'd0, rx_trig_sel = 3'd0;
  logic tx_eot_mode = 1'b0, tx_shift_idle = 1'b0;
  logic rx_overrun_pulse = 1'b0, rx_break_pulse = 1'b0;
  logic rx_parity_pulse = 1'b0, rx_frame_pulse = 1'b0;
  logic rx_timeout_evt = 1'b0, cts_change = 1'b0;
  logic mask_set_we = 1'b0, mask_clr_we = 1'b0, int_clr_we = 1'b0, err_clr_we = 1'b0;
  logic [7:0] mask_set_bits = '0, mask_clr_bits = '0, int_clr_bits = '0;
  logic rx_flow_en = 1'b0, sw_rts = 1'b0;
  logic [7:0] raw_status, masked_status;
  logic irq, rts_out;
  logic [3:0] err_status;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  item_t sb_q[$];
  event do_check, check_done;

  always #10 clk = ~clk;  // 50 MHz

  uart_irq_ctrl #(.DEPTH(DEPTH)) i_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel),
    .tx_eot_mode(tx_eot_mode), .tx_shift_idle(tx_shift_idle),
    .rx_overrun_pulse(rx_overrun_pulse), .rx_break_pulse(rx_break_pulse),
    .rx_parity_pulse(rx_parity_pulse), .rx_frame_pulse(rx_frame_pulse),
    .rx_timeout_evt(rx_timeout_evt), .cts_change(cts_change),
    .mask_set_we(mask_set_we), .mask_set_bits(mask_set_bits),
    .mask_clr_we(mask_clr_we), .mask_clr_bits(mask_clr_bits),
    .int_clr_we(int_clr_we), .int_clr_bits(int_clr_bits),
    .err_clr_we(err_clr_we), .rx_flow_en(rx_flow_en), .sw_rts(sw_rts),
    .raw_status(raw_status), .masked_status(masked_status), .irq(irq),
    .err_status(err_status), .rts_out(rts_out)
  );

  function automatic logic [7:0] observe(int kind);
    case (kind)
      K_RAW:   return raw_status;
      K_MSK:   return masked_status;
      K_IRQ:   return {7'd0, irq};
      K_ERR:   return {4'd0, err_status};
      default: return {7'd0, rts_out};
    endcase
  endfunction

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(do_check);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = sb_q.pop_front();
        got = observe(it.kind);
        n_tests++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s (view %0d): got %h expected %h", it.req, it.kind, got, it.exp);
        end
      end
      ->check_done;
    end
  end

  task automatic expect_val(int kind, logic [7:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic check_now();
    ->do_check;
    @(check_done);
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_int(logic [7:0] bits);
    int_clr_we = 1'b1; int_clr_bits = bits;
    step();
    int_clr_we = 1'b0; int_clr_bits = '0;
  endtask

  task automatic clr_err();
    err_clr_we = 1'b1;
    step();
    err_clr_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    // R11 reset state
    expect_val(K_RAW, 8'h00, "R11 raw");
    expect_val(K_MSK, 8'h00, "R11 masked");
    expect_val(K_IRQ, 8'h00, "R11 irq");
    expect_val(K_ERR, 8'h00, "R11 err");
    expect_val(K_RTS, 8'h00, "R11 rts");
    check_now();

    // R1 / R2: receive threshold 4/8 -> 8
    rx_trig_sel = 3'd2;
    rx_level = 7; step();
    expect_val(K_RAW, 8'h00, "R1 below 4/8"); check_now();
    rx_level = 8; step();
    expect_val(K_RAW, 8'h01, "R2 rx crossing"); check_now();
    clr_int(8'h01);
    expect_val(K_RAW, 8'h00, "R8 w1c rx"); check_now();
    rx_level = 10; step(2);
    expect_val(K_RAW, 8'h00, "R2 no retrigger"); check_now();
    rx_trig_sel = 3'd4;
    rx_level = 13; step();
    expect_val(K_RAW, 8'h00, "R1 below 7/8"); check_now();
    rx_level = 14; step();
    expect_val(K_RAW, 8'h01, "R1 7/8 threshold"); check_now();
    clr_int(8'h01);
    rx_level = 0; step();

    // R3: transmit FIFO mode, threshold 1/8 -> 2
    tx_trig_sel = 3'd0;
    tx_level = 5; step();
    expect_val(K_RAW, 8'h00, "R3 rising ignored"); check_now();
    tx_level = 3; step();
    expect_val(K_RAW, 8'h00, "R3 above threshold"); check_now();
    tx_level = 2; step();
    expect_val(K_RAW, 8'h02, "R3 tx falling crossing"); check_now();
    clr_int(8'h02);

    // R4: end-of-transmission mode
    tx_eot_mode = 1'b1;
    tx_level = 5; step();
    tx_level = 2; step();
    expect_val(K_RAW, 8'h00, "R4 crossing ignored in eot"); check_now();
    tx_level = 0; step();
    expect_val(K_RAW, 8'h00, "R4 shifter busy"); check_now();
    tx_shift_idle = 1'b1; step();
    expect_val(K_RAW, 8'h02, "R4 eot reached"); check_now();
    clr_int(8'h02);
    tx_eot_mode = 1'b0;

    // R5: timeout and CTS change
    rx_timeout_evt = 1'b1; step(); rx_timeout_evt = 1'b0;
    expect_val(K_RAW, 8'h04, "R5 timeout bit"); check_now();
    cts_change = 1'b1; step(); cts_change = 1'b0;
    expect_val(K_RAW, 8'h84, "R5 cts bit"); check_now();
    clr_int(8'h84);

    // R6 / R7: masking and registered irq; rx threshold 1/8 -> 2
    rx_trig_sel = 3'd0;
    mask_set_we = 1'b1; mask_set_bits = 8'h01; rx_level = 2;
    step();
    mask_set_we = 1'b0; mask_set_bits = '0;
    expect_val(K_RAW, 8'h01, "R6 raw rx");
    expect_val(K_MSK, 8'h01, "R6 masked rx");
    expect_val(K_IRQ, 8'h00, "R7 irq lags");
    check_now();
    step();
    expect_val(K_IRQ, 8'h01, "R7 irq high"); check_now();
    mask_set_we = 1'b1; mask_set_bits = 8'h01;
    mask_clr_we = 1'b1; mask_clr_bits = 8'h01;
    step();
    mask_set_we = 1'b0; mask_clr_we = 1'b0; mask_set_bits = '0; mask_clr_bits = '0;
    expect_val(K_MSK, 8'h01, "R6 set beats clear"); check_now();
    mask_clr_we = 1'b1; mask_clr_bits = 8'h01;
    step();
    mask_clr_we = 1'b0; mask_clr_bits = '0;
    expect_val(K_MSK, 8'h00, "R6 mask cleared");
    expect_val(K_IRQ, 8'h01, "R7 irq still high");
    check_now();
    step();
    expect_val(K_IRQ, 8'h00, "R7 irq low"); check_now();

    // R8: event beats clear in the same cycle
    int_clr_we = 1'b1; int_clr_bits = 8'h04; rx_timeout_evt = 1'b1;
    step();
    int_clr_we = 1'b0; int_clr_bits = '0; rx_timeout_evt = 1'b0;
    expect_val(K_RAW, 8'h05, "R8 set wins"); check_now();
    clr_int(8'h05);
    expect_val(K_RAW, 8'h00, "R8 clear two bits"); check_now();

    // R9: error register
    rx_frame_pulse = 1'b1; step(); rx_frame_pulse = 1'b0;
    expect_val(K_ERR, 8'h01, "R9 framing");
    expect_val(K_RAW, 8'h08, "R5 framing raw");
    check_now();
    rx_overrun_pulse = 1'b1; step(); rx_overrun_pulse = 1'b0;
    expect_val(K_ERR, 8'h09, "R9 overrun");
    expect_val(K_RAW, 8'h48, "R5 overrun raw");
    check_now();
    clr_err();
    expect_val(K_ERR, 8'h00, "R9 any write clears");
    expect_val(K_RAW, 8'h48, "R9 raw untouched");
    check_now();
    err_clr_we = 1'b1; rx_parity_pulse = 1'b1;
    step();
    err_clr_we = 1'b0; rx_parity_pulse = 1'b0;
    expect_val(K_ERR, 8'h02, "R9 pulse beats clear");
    expect_val(K_RAW, 8'h58, "R5 parity raw");
    check_now();
    rx_break_pulse = 1'b1; step(); rx_break_pulse = 1'b0;
    expect_val(K_ERR, 8'h06, "R9 break");
    expect_val(K_RAW, 8'h78, "R5 break raw");
    check_now();
    clr_err();
    clr_int(8'hFF);

    // R10: RTS
    rx_flow_en = 1'b1; rx_level = 15; step();
    expect_val(K_RTS, 8'h01, "R10 space left"); check_now();
    rx_level = 16; step();
    expect_val(K_RTS, 8'h00, "R10 fifo full"); check_now();
    rx_flow_en = 1'b0; sw_rts = 1'b1; step();
    expect_val(K_RTS, 8'h01, "R10 software level"); check_now();
    sw_rts = 1'b0; step();
    expect_val(K_RTS, 8'h00, "R10 software low"); check_now();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule